// File: doc/BRIEF.md
# Shared Interrupt Pin to Legacy IRQ Router

This block steers eight shared interrupt links onto sixteen legacy level-sensitive interrupt request lines. Each link has an 8-bit route register holding a disable flag and a 4-bit target line number. Software reads and writes these registers through a small synchronous register port.

Any number of device interrupt sources feed the router. Each source is a level input with a static link assignment. A link is active while any source assigned to it is high. An output line is high while at least one link has a usable route to it and is active.

A route is usable only if its disable flag is clear and its target lies in a fixed set of permitted line numbers. A route that names a line outside that set acts exactly like a disabled link. Route registers can be rewritten while their link is active. The contribution then moves from the old line to the new one on the following cycle.

Top module: `irq_pin_router`

## Requirements
- R1: After reset every route register reads 0x80 (disabled) and all sixteen output lines are low.
- R2: A write stores only bit 7 (disable) and bits 3:0 (target line); bits 6:4 read back as zero. The value of the register at `cfg_addr` appears on `cfg_rdata` one cycle after the address is presented, and a register changes only on a write to its own address.
- R3: While bit 7 of a link's route register is set, that link drives no output line, whatever its sources do.
- R4: Only target lines 3–7, 9–12 and 14–15 are permitted (mask 0xDEF8, bit n for line n). A route naming line 0, 1, 2, 8 or 13 behaves as a disabled link, and those five outputs never go high.
- R5: A link is active while at least one source assigned to it is high (source s is assigned by `src_link[3s+2:3s]`, value 0–7 = register address of the link). Its routed line rises when the first source goes high and falls only when the last one goes low.
- R6: When several usable, active links route to the same line, the line is high while any of them is active.
- R7: Rewriting an active link's route with a different target moves its contribution: the old line drops and the new line, if usable, rises.
- R8: Writing a register with the value it already holds leaves every output line unchanged.
- R9: Output lines are registered. A change of sources, or a route write, at a clock edge shows on `irq_out` after the next edge, and never earlier.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Route register write strobe |
| cfg_addr | input | 3 | Route register index (link number) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data for `cfg_addr` |
| src_level | input | N_SRC (16) | Level of each device interrupt source |
| src_link | input | 3*N_SRC (48) | Link assignment of each source, 3 bits per source |
| irq_out | output | 16 | Level-sensitive legacy interrupt lines |

## Verification
The assertions assume that `src_link` is steady between changes and that `cfg_addr` always names one of the eight links. This holds by construction with a 3-bit address and eight links. They also assume reset is applied once at the start before any check matters. The stimulus changes sources, assignments and register writes only on the falling edge. Random write values are drawn so that permitted lines, reserved lines, disabled routes and repeated identical values all occur. Assignments are redrawn only occasionally, which keeps long stretches in which several links share a line.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ROUTE_W  = 8;
  localparam int DIS_BIT  = 7;
  localparam int SEL_W    = 4;
  localparam logic [ROUTE_W-1:0] KEEP_BITS  = 8'h8F;
  localparam logic [ROUTE_W-1:0] ROUTE_INIT = 8'h80;

  // A route drives a line only when enabled and aimed at a permitted line.
  function automatic logic route_usable(input logic [ROUTE_W-1:0] r,
                                        input logic [15:0] allowed);
    return !r[DIS_BIT] && allowed[r[SEL_W-1:0]];
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int N_LINKS = 8,
  localparam int ADDR_W = $clog2(N_LINKS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [ROUTE_W-1:0]           wdata,
  output logic [ROUTE_W-1:0]           rdata,
  output logic [N_LINKS*ROUTE_W-1:0]   routes_flat
);
  logic [ROUTE_W-1:0] tbl [N_LINKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINKS; i++) tbl[i] <= ROUTE_INIT;
      rdata <= '0;
    end else begin
      if (we) tbl[addr] <= wdata & KEEP_BITS;
      rdata <= tbl[addr];
    end
  end

  for (genvar g = 0; g < N_LINKS; g++) begin : g_flat
    assign routes_flat[g*ROUTE_W +: ROUTE_W] = tbl[g];
  end

  // R2: a write lands, masked, in the addressed register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> tbl[$past(addr)] == ($past(wdata) & KEEP_BITS));

  // R2: no register moves without a write
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(routes_flat));
endmodule

// File: rtl/irq_link_merge.sv
module irq_link_merge #(
  parameter int N_SRC   = 16,
  parameter int N_LINKS = 8,
  localparam int LSEL_W = $clog2(N_LINKS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_SRC-1:0]          src_level,
  input  logic [N_SRC*LSEL_W-1:0]   src_link,
  output logic [N_LINKS-1:0]        link_active
);
  always_comb begin
    link_active = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (src_level[s]) link_active[src_link[s*LSEL_W +: LSEL_W]] = 1'b1;
    end
  end

  // R5: with no source high no link may count as active
  a_r5_idle_sources_quiet: assert property (@(posedge clk) disable iff (rst)
    (src_level == '0) |-> (link_active == '0));

  // R5: any high source makes some link active
  a_r5_source_reaches_link: assert property (@(posedge clk) disable iff (rst)
    (src_level != '0) |-> (link_active != '0));
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive
  import irq_route_pkg::*;
#(
  parameter int N_LINKS = 8,
  parameter int N_IRQ   = 16,
  parameter logic [15:0] ALLOWED = 16'hDEF8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_LINKS*ROUTE_W-1:0]  routes_flat,
  input  logic [N_LINKS-1:0]          link_active,
  output logic [N_IRQ-1:0]            irq_q
);
  logic [N_IRQ-1:0]   req;
  logic [N_LINKS-1:0] usable;
  logic [N_LINKS-1:0] dis_bits;

  for (genvar l = 0; l < N_LINKS; l++) begin : g_link
    assign usable[l]   = route_usable(routes_flat[l*ROUTE_W +: ROUTE_W], ALLOWED);
    assign dis_bits[l] = routes_flat[l*ROUTE_W + DIS_BIT];
  end

  always_comb begin
    req = '0;
    for (int l = 0; l < N_LINKS; l++) begin
      if (link_active[l] && usable[l])
        req[routes_flat[l*ROUTE_W +: SEL_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= req;
  end

  // R4: reserved lines never rise
  a_r4_reserved_lines_low: assert property (@(posedge clk) disable iff (rst)
    (irq_q & ~ALLOWED[N_IRQ-1:0]) == '0);

  // R5: a raised line needs an active link one cycle earlier
  a_r5_line_needs_active: assert property (@(posedge clk) disable iff (rst)
    (|irq_q) |-> $past(|link_active));

  // R3: with every link disabled all lines are low next cycle
  a_r3_all_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (&dis_bits) |=> (irq_q == '0));
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_route_pkg::*;
#(
  parameter int N_SRC   = 16,
  parameter int N_LINKS = 8,
  parameter int N_IRQ   = 16,
  parameter logic [15:0] ALLOWED = 16'hDEF8,
  localparam int LSEL_W = $clog2(N_LINKS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [LSEL_W-1:0]        cfg_addr,
  input  logic [ROUTE_W-1:0]       cfg_wdata,
  output logic [ROUTE_W-1:0]       cfg_rdata,
  input  logic [N_SRC-1:0]         src_level,
  input  logic [N_SRC*LSEL_W-1:0]  src_link,
  output logic [N_IRQ-1:0]         irq_out
);
  logic [N_LINKS*ROUTE_W-1:0] routes_flat;
  logic [N_LINKS-1:0]         link_active;

  irq_route_regs #(.N_LINKS(N_LINKS)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .routes_flat(routes_flat)
  );

  irq_link_merge #(.N_SRC(N_SRC), .N_LINKS(N_LINKS)) u_merge (
    .clk(clk), .rst(rst), .src_level(src_level), .src_link(src_link),
    .link_active(link_active)
  );

  irq_line_drive #(.N_LINKS(N_LINKS), .N_IRQ(N_IRQ), .ALLOWED(ALLOWED)) u_drive (
    .clk(clk), .rst(rst), .routes_flat(routes_flat),
    .link_active(link_active), .irq_q(irq_out)
  );

  // R8: an unchanged route with unchanged sources keeps the lines steady
  a_r8_same_write_steady: assert property (@(posedge clk) disable iff (rst)
    ($stable(routes_flat) && $stable(src_level) && $stable(src_link)
     && $past($stable(routes_flat) && $stable(src_level) && $stable(src_link)))
    |-> $stable(irq_out));
endmodule

// File: tb/irq_pin_router_tb_top.sv
module irq_pin_router_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic [15:0] src_level = 0;
  logic [47:0] src_link = 0;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_reg [8];

  always #2 clk = ~clk;

  irq_pin_router dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_level(src_level),
    .src_link(src_link), .irq_out(irq_out)
  );

  function automatic logic [15:0] exp_irq();
    logic [15:0] e = 0;
    logic [7:0]  act = 0;
    for (int s = 0; s < 16; s++) if (src_level[s]) act[src_link[s*3 +: 3]] = 1;
    for (int l = 0; l < 8; l++)
      if (act[l] && !m_reg[l][7] && ((16'hDEF8 >> m_reg[l][3:0]) & 1)) e[m_reg[l][3:0]] = 1;
    return e;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit we, input logic [2:0] a, input logic [7:0] d, input string tag);
    logic [15:0] e;
    e = exp_irq();
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    if (we) m_reg[a] = d & 8'h8F;
    @(negedge clk);
    chk(irq_out, e, tag);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    cfg_we = 0; cfg_addr = a;
    @(posedge clk); @(negedge clk);
    chk({8'h0, cfg_rdata}, {8'h0, m_reg[a]}, tag);
  endtask

  task automatic assign_all(input logic [2:0] l);
    for (int s = 0; s < 16; s++) src_link[s*3 +: 3] = l;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 R2 R3 R4 R5 R6 R7 R8 R9 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    void'($urandom(32'd4242));
    for (int l = 0; l < 8; l++) m_reg[l] = 8'h80;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(irq_out, 16'h0, "R1 lines low after reset");
    for (int l = 0; l < 8; l++) rd(l[2:0], "R1 reset value 0x80");

    // R2 masking on write
    tick(1, 3'd2, 8'hFF, "R2 write");
    rd(3'd2, "R2 bits 6:4 read zero");
    tick(1, 3'd2, 8'h75, "R2 write");
    rd(3'd2, "R2 masked readback");
    rd(3'd1, "R2 neighbour untouched");

    // R9 latency: link 0 to line 5, source 0 on link 0
    assign_all(3'd7);
    src_link[2:0] = 3'd0;
    tick(1, 3'd0, 8'h05, "R9 route write");
    src_level = 16'h0001;
    #0 chk(irq_out, 16'h0, "R9 no early change");
    tick(0, 0, 0, "R9 one cycle latency");
    chk(irq_out, 16'h0020, "R5 first source raises line 5");

    // R5 second source on same link, drop first
    src_link[5:3] = 3'd0;
    src_level = 16'h0003; tick(0, 0, 0, "R5 two sources");
    src_level = 16'h0002; tick(0, 0, 0, "R5 one remaining");
    chk(irq_out, 16'h0020, "R5 stays high until last source");
    src_level = 16'h0000; tick(0, 0, 0, "R5 last source low");
    chk(irq_out, 16'h0, "R5 falls after last");

    // R3 disable
    src_level = 16'h0001;
    tick(0, 0, 0, "R3 pre");
    tick(1, 3'd0, 8'h85, "R3 disable write");
    tick(0, 0, 0, "R3 disabled link quiet");
    chk(irq_out, 16'h0, "R3 disabled link drives nothing");

    // R4 reserved lines
    tick(1, 3'd0, 8'h08, "R4 route to 8");
    tick(0, 0, 0, "R4 reserved line 8 quiet");
    chk(irq_out, 16'h0, "R4 reserved acts disabled");
    tick(1, 3'd0, 8'h0D, "R4 route to 13");
    tick(0, 0, 0, "R4 reserved line 13 quiet");

    // R7 live reroute
    tick(1, 3'd0, 8'h0A, "R7 route to 10");
    tick(0, 0, 0, "R7 line 10 high");
    chk(irq_out, 16'h0400, "R7 line 10 high");
    tick(1, 3'd0, 8'h03, "R7 reroute to 3");
    tick(0, 0, 0, "R7 moved to 3");
    chk(irq_out, 16'h0008, "R7 contribution moved");

    // R8 same value rewrite
    prev = irq_out;
    tick(1, 3'd0, 8'h03, "R8 same value");
    tick(0, 0, 0, "R8 same value");
    chk(irq_out, prev, "R8 output unchanged");

    // R6 two links to line 3
    src_link[5:3] = 3'd1;
    tick(1, 3'd1, 8'h03, "R6 link1 to 3");
    src_level = 16'h0003; tick(0, 0, 0, "R6 both");
    src_level = 16'h0002; tick(0, 0, 0, "R6 one left");
    chk(irq_out, 16'h0008, "R6 shared line held");
    src_level = 16'h0000; tick(0, 0, 0, "R6 none");

    // random mix, R5 R6 R7 R8
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] v;
      if (($urandom % 40) == 0)
        for (int s = 0; s < 16; s++) src_link[s*3 +: 3] = 3'($urandom % 8);
      src_level = 16'($urandom) & 16'($urandom);
      case ($urandom % 6)
        0: v = 8'h80;
        1: v = 8'($urandom);
        2: v = m_reg[i % 8];
        default: v = {4'h0, 4'($urandom)};
      endcase
      if (($urandom % 3) == 0) tick(1, 3'(i % 8), v, "R5 R6 R7 R8 random");
      else tick(0, 0, 0, "R5 R6 random");
      if ((i % 97) == 0) rd(3'($urandom % 8), "R2 random readback");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule